// File: doc/BRIEF.md
# Two-Channel DMA Register Bank with Reload Latches

This block is the register file that a processor sees for a two-channel byte DMA controller. One shared index/status register holds the completion and suspend flags, two global control bits and a channel-select bit. Behind one small address window sit, per channel, a mode register and three 16-bit working registers (source address, destination address, transfer count). Each 16-bit register appears as a low and a high byte address.

Every working register has a reload latch behind it. A processor write normally updates both copies. A mode option routes writes to the latch only, so that the next block can be prepared while the current one runs. A self-clearing reload strobe in the mode register copies the latches into the working registers. A global disable bit can keep the source and destination addresses out of that copy, so only the count is restored.

The transfer engine reads the working registers and the mode bits from dedicated outputs. It reports count underflow and interrupt suspension through one-cycle set pulses.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every address reads 0x00 for both channels, and the working-register outputs and mode outputs are all zero.
- R2: Bit 7 of the index/status register (address 0) selects the visible channel (0 or 1). Reads and writes at addresses 1 to 7 reach only the selected channel's registers.
- R3: Address map: 1 is the mode register, 2/3 the source low/high byte, 4/5 the destination low/high byte, and 6/7 the count low/high byte.
- R4: When mode bit 4 of the selected channel is 0, a register byte write updates both the reload latch and the working register. The new value is visible on the next read.
- R5: When mode bit 4 of the selected channel is 1, a register byte write updates only the reload latch, and the working register keeps its value.
- R6: Writing the mode register with bit 6 set copies all three latches of that channel into its working registers, taking effect one clock later. Mode bit 6 always reads 0.
- R7: While index/status bit 5 is 1, a reload leaves the source and destination working registers of both channels unchanged, but the count is still reloaded.
- R8: Index/status bits 0 and 2 are the count-underflow flags of channels 0 and 1. Bits 1 and 3 are their suspend flags. Each flag is set one clock after its input pulse.
- R9: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A set pulse in the same cycle as a clearing write leaves the flag set.
- R10: Index/status bit 6 reads 0 whatever is written. Bits 4, 5 and 7 read back as written, and bit 4 drives the suspend-all output.
- R11: The per-channel source, destination, count and mode outputs always show the working registers and stored mode values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| ufSet | input | 2 | Per-channel count-underflow set pulse |
| susSet | input | 2 | Per-channel suspend set pulse |
| chMode | output | 2x8 | Stored mode register per channel |
| chSrc | output | 2x16 | Source working register per channel |
| chDst | output | 2x16 | Destination working register per channel |
| chCnt | output | 2x16 | Count working register per channel |
| suspendAll | output | 1 | Index/status bit 4 |

## Verification
The properties assume at most one bus access per cycle. They also assume that a write to the mode register carries no simultaneous byte write, so a reload never competes with a direct write to the same working register. The bench drives the bus through one task that issues exactly one write per call, and it raises flag pulses only through the flag tasks. Flag-versus-write collisions are produced on purpose in a single combined task, so the set-wins rule is exercised without breaking the one-access assumption.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  localparam int NCH    = 2;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int NREG   = 3;
  localparam int ADDR_W = 3;

  // register slot indices inside a channel
  localparam int SLOT_SRC = 0;
  localparam int SLOT_DST = 1;
  localparam int SLOT_CNT = 2;

  // index/status bit positions
  localparam int IX_SUSPALL = 4;
  localparam int IX_RLDDIS  = 5;
  localparam int IX_RSVD    = 6;
  localparam int IX_CHSEL   = 7;
  localparam int NFLAG      = 2 * NCH;

  // mode bit positions
  localparam int MD_LATCHONLY = 4;
  localparam int MD_RELOAD    = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_IDX  = 3'd0,
    A_MODE = 3'd1,
    A_SRCL = 3'd2,
    A_SRCH = 3'd3,
    A_DSTL = 3'd4,
    A_DSTH = 3'd5,
    A_CNTL = 3'd6,
    A_CNTH = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic            idxWr;
    logic            modeWr;
    logic [NREG-1:0] regWr;
    logic            hiByte;
    logic            chSel;
    logic            latchOnly;
    logic            reloadCnt;
    logic            reloadAddr;
  } strobe_t;

endpackage

// File: rtl/dma_regbank_ctrl.sv
module dma_regbank_ctrl
  import dma_regbank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              chIdx,
  input  logic              rldDis,
  input  logic              selLatchOnly,
  output strobe_t           stb,
  output regAddr_e          rdSel
);

  always_comb begin
    rdSel         = regAddr_e'(addr);
    stb           = '0;
    stb.chSel     = chIdx;
    stb.hiByte    = addr[0];
    stb.latchOnly = selLatchOnly;
    if (wrEn) begin
      unique case (rdSel)
        A_IDX:  stb.idxWr = 1'b1;
        A_MODE: begin
          stb.modeWr = 1'b1;
          if (wrData[MD_RELOAD]) begin
            stb.reloadCnt  = 1'b1;
            stb.reloadAddr = !rldDis;
          end
        end
        A_SRCL, A_SRCH: stb.regWr[SLOT_SRC] = 1'b1;
        A_DSTL, A_DSTH: stb.regWr[SLOT_DST] = 1'b1;
        A_CNTL, A_CNTH: stb.regWr[SLOT_CNT] = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_regbank_dp.sv
module dma_regbank_dp
  import dma_regbank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  regAddr_e                    rdSel,
  input  logic [BYTE_W-1:0]           wrData,
  input  logic [NCH-1:0]              ufSet,
  input  logic [NCH-1:0]              susSet,
  output logic [BYTE_W-1:0]           rdData,
  output logic [BYTE_W-1:0]           idxQ,
  output logic                        selLatchOnly,
  output logic [NCH-1:0][BYTE_W-1:0]  modeArr,
  output logic [NCH-1:0][REG_W-1:0]   srcArr,
  output logic [NCH-1:0][REG_W-1:0]   dstArr,
  output logic [NCH-1:0][REG_W-1:0]   cntArr
);

  logic [NCH-1:0][NREG-1:0][REG_W-1:0] workArr;
  logic [NFLAG-1:0]                    flagSet;

  // flag order: uf0, sus0, uf1, sus1
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      flagSet[2*c]   = ufSet[c];
      flagSet[2*c+1] = susSet[c];
    end
  end

  // index/status register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else begin
      for (int b = 0; b < NFLAG; b++) begin
        idxQ[b] <= flagSet[b] | (idxQ[b] & ~(stb.idxWr & ~wrData[b]));
      end
      idxQ[IX_RSVD] <= 1'b0;
      if (stb.idxWr) begin
        idxQ[IX_SUSPALL] <= wrData[IX_SUSPALL];
        idxQ[IX_RLDDIS]  <= wrData[IX_RLDDIS];
        idxQ[IX_CHSEL]   <= wrData[IX_CHSEL];
      end
    end
  end

  // per-channel mode, latches and working registers
  for (genvar c = 0; c < NCH; c++) begin : gCh
    logic [BYTE_W-1:0] modeQ;
    logic              hit;

    assign hit = (stb.chSel == c[0]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ <= '0;
      end else if (stb.modeWr && hit) begin
        modeQ <= wrData & ~(BYTE_W'(1) << MD_RELOAD);
      end
    end
    assign modeArr[c] = modeQ;

    for (genvar r = 0; r < NREG; r++) begin : gReg
      logic [REG_W-1:0] latchQ;
      logic [REG_W-1:0] workQ;
      logic             doReload;

      if (r == SLOT_CNT) begin : gCntRld
        assign doReload = stb.reloadCnt && hit;
      end else begin : gAddrRld
        assign doReload = stb.reloadAddr && hit;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          latchQ <= '0;
          workQ  <= '0;
        end else if (stb.regWr[r] && hit) begin
          if (stb.hiByte) latchQ[REG_W-1:BYTE_W] <= wrData;
          else            latchQ[BYTE_W-1:0]     <= wrData;
          if (!stb.latchOnly) begin
            if (stb.hiByte) workQ[REG_W-1:BYTE_W] <= wrData;
            else            workQ[BYTE_W-1:0]     <= wrData;
          end
        end else if (doReload) begin
          workQ <= latchQ;
        end
      end
      assign workArr[c][r] = workQ;
    end

    assign srcArr[c] = workArr[c][SLOT_SRC];
    assign dstArr[c] = workArr[c][SLOT_DST];
    assign cntArr[c] = workArr[c][SLOT_CNT];
  end

  assign selLatchOnly = modeArr[idxQ[IX_CHSEL]][MD_LATCHONLY];

  // read mux
  always_comb begin
    logic ch;
    ch = idxQ[IX_CHSEL];
    unique case (rdSel)
      A_IDX:   rdData = idxQ & ~(BYTE_W'(1) << IX_RSVD);
      A_MODE:  rdData = modeArr[ch];
      A_SRCL:  rdData = workArr[ch][SLOT_SRC][BYTE_W-1:0];
      A_SRCH:  rdData = workArr[ch][SLOT_SRC][REG_W-1:BYTE_W];
      A_DSTL:  rdData = workArr[ch][SLOT_DST][BYTE_W-1:0];
      A_DSTH:  rdData = workArr[ch][SLOT_DST][REG_W-1:BYTE_W];
      A_CNTL:  rdData = workArr[ch][SLOT_CNT][BYTE_W-1:0];
      A_CNTH:  rdData = workArr[ch][SLOT_CNT][REG_W-1:BYTE_W];
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic [BYTE_W-1:0]          wrData,
  output logic [BYTE_W-1:0]          rdData,
  input  logic [NCH-1:0]             ufSet,
  input  logic [NCH-1:0]             susSet,
  output logic [NCH-1:0][BYTE_W-1:0] chMode,
  output logic [NCH-1:0][REG_W-1:0]  chSrc,
  output logic [NCH-1:0][REG_W-1:0]  chDst,
  output logic [NCH-1:0][REG_W-1:0]  chCnt,
  output logic                       suspendAll
);

  strobe_t           stb;
  regAddr_e          rdSel;
  logic [BYTE_W-1:0] idxQ;
  logic              selLatchOnly;

  dma_regbank_ctrl u_ctrl (
    .wrEn         (wrEn),
    .addr         (addr),
    .wrData       (wrData),
    .chIdx        (idxQ[IX_CHSEL]),
    .rldDis       (idxQ[IX_RLDDIS]),
    .selLatchOnly (selLatchOnly),
    .stb          (stb),
    .rdSel        (rdSel)
  );

  dma_regbank_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rdSel        (rdSel),
    .wrData       (wrData),
    .ufSet        (ufSet),
    .susSet       (susSet),
    .rdData       (rdData),
    .idxQ         (idxQ),
    .selLatchOnly (selLatchOnly),
    .modeArr      (chMode),
    .srcArr       (chSrc),
    .dstArr       (chDst),
    .cntArr       (chCnt)
  );

  assign suspendAll = idxQ[IX_SUSPALL];

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
  import dma_regbank_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wrEn,
  input logic [BYTE_W-1:0]          wrData,
  input logic [BYTE_W-1:0]          rdData,
  input logic [NCH-1:0]             ufSet,
  input logic [NCH-1:0]             susSet,
  input logic [NCH-1:0][BYTE_W-1:0] chMode,
  input logic [NCH-1:0][REG_W-1:0]  chSrc,
  input logic [NCH-1:0][REG_W-1:0]  chDst,
  input logic [NCH-1:0][REG_W-1:0]  chCnt,
  input logic [BYTE_W-1:0]          idxQ
);

  // R2: writes to the window with channel 0 selected leave channel 1 alone
  a_r2_bank_isolation: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= 3'd2 && !idxQ[IX_CHSEL])
      |=> ($stable(chSrc[1]) && $stable(chDst[1]) && $stable(chCnt[1])));

  // R4: write-through updates the working source low byte
  a_r4_write_through: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && !idxQ[IX_CHSEL] && !chMode[0][MD_LATCHONLY])
      |=> (chSrc[0][BYTE_W-1:0] == $past(wrData)));

  // R5: latch-only writes do not disturb the working register
  a_r5_latch_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && !idxQ[IX_CHSEL] && chMode[0][MD_LATCHONLY])
      |=> $stable(chSrc[0]));

  // R6: reload strobe never reads back
  a_r6_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd1) |-> !rdData[MD_RELOAD]);

  // R7: reload-disable keeps both channels' address registers
  a_r7_reload_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1 && wrData[MD_RELOAD] && idxQ[IX_RLDDIS])
      |=> ($stable(chSrc[0]) && $stable(chSrc[1]) && $stable(chDst[0]) && $stable(chDst[1])));

  // R9: a set pulse always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ufSet[0] |=> idxQ[0]);

  // R9: writing 0 without a pulse clears the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && !wrData[2] && !ufSet[1]) |=> !idxQ[2]);

  // R10: reserved bit never reads 1
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd0) |-> !rdData[IX_RSVD]);

endmodule

bind dma_regbank dma_regbank_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .ufSet  (ufSet),
  .susSet (susSet),
  .chMode (chMode),
  .chSrc  (chSrc),
  .chDst  (chDst),
  .chCnt  (chCnt),
  .idxQ   (u_dp.idxQ)
);

// File: tb/sim_dma_regbank.sv
`timescale 1ns/1ps
module sim_dma_regbank;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       addr = '0;
  logic             wrEn = 1'b0;
  logic [7:0]       wrData = '0;
  logic [7:0]       rdData;
  logic [1:0]       ufSet = '0;
  logic [1:0]       susSet = '0;
  logic [1:0][7:0]  chMode;
  logic [1:0][15:0] chSrc;
  logic [1:0][15:0] chDst;
  logic [1:0][15:0] chCnt;
  logic             suspendAll;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_regbank u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ufSet(ufSet), .susSet(susSet), .chMode(chMode),
    .chSrc(chSrc), .chDst(chDst), .chCnt(chCnt), .suspendAll(suspendAll)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    check(req, {24'd0, rdData}, {24'd0, exp});
  endtask

  task automatic pulse(input logic [1:0] uf, input logic [1:0] sus);
    @(negedge clk);
    ufSet = uf; susSet = sus;
    @(negedge clk);
    ufSet = '0; susSet = '0;
  endtask

  task automatic t_reset;
    for (int ch = 0; ch < 2; ch++) begin
      if (ch == 1) wr(3'd0, 8'h80);
      for (int a = 1; a < 8; a++) rdChk("R1", 3'(a), 8'h00);
    end
    wr(3'd0, 8'h00);
    rdChk("R1", 3'd0, 8'h00);
    check("R1", {chSrc, chDst}, '0);
    check("R1", {16'd0, chCnt[0] | chCnt[1]}, 32'd0);
    check("R1", {16'd0, chMode}, 32'd0);
  endtask

  task automatic t_window;
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33);
    wr(3'd5, 8'h44); wr(3'd6, 8'h55); wr(3'd7, 8'h66);
    wr(3'd0, 8'h80);
    wr(3'd2, 8'hAA); wr(3'd3, 8'hBB); wr(3'd4, 8'hCC);
    wr(3'd5, 8'hDD); wr(3'd6, 8'hEE); wr(3'd7, 8'hFF);
    rdChk("R3", 3'd2, 8'hAA); rdChk("R3", 3'd5, 8'hDD); rdChk("R3", 3'd7, 8'hFF);
    check("R11", {16'd0, chSrc[1]}, 32'h0000BBAA);
    check("R11", {chDst[1], chCnt[1]}, 32'hDDCCFFEE);
    wr(3'd0, 8'h00);
    rdChk("R2", 3'd2, 8'h11); rdChk("R2", 3'd3, 8'h22);
    rdChk("R2", 3'd4, 8'h33); rdChk("R2", 3'd6, 8'h55);
    check("R4", {chSrc[0], chCnt[0]}, 32'h22116655);
    // R4: latch matched working register, so a reload changes nothing
    wr(3'd1, 8'h40);
    check("R4", {chSrc[0], chDst[0]}, 32'h22114433);
    rdChk("R6", 3'd1, 8'h00);
  endtask

  task automatic t_latch;
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h99); wr(3'd7, 8'h77);
    rdChk("R5", 3'd2, 8'h11); rdChk("R5", 3'd7, 8'h66);
    check("R5", {16'd0, chSrc[0]}, 32'h00002211);
    wr(3'd1, 8'h50);
    rdChk("R6", 3'd2, 8'h99); rdChk("R6", 3'd7, 8'h77);
    rdChk("R6", 3'd1, 8'h10);
    check("R11", {16'd0, chMode[0]}, 32'h00000010);
    check("R6", {16'd0, chCnt[0]}, 32'h00007755);
  endtask

  task automatic t_rlddis;
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h01); wr(3'd4, 8'h02); wr(3'd6, 8'h03);
    wr(3'd0, 8'hA0);
    wr(3'd1, 8'h50);
    rdChk("R7", 3'd2, 8'hAA); rdChk("R7", 3'd4, 8'hCC); rdChk("R7", 3'd6, 8'h03);
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h50);
    rdChk("R7", 3'd2, 8'h01); rdChk("R7", 3'd4, 8'h02);
  endtask

  task automatic t_flags;
    pulse(2'b10, 2'b00);
    rdChk("R8", 3'd0, 8'h84);
    pulse(2'b00, 2'b01);
    rdChk("R8", 3'd0, 8'h86);
    wr(3'd0, 8'h8F);
    rdChk("R9", 3'd0, 8'h86);
    // clearing write to bit 2 collides with its set pulse
    @(negedge clk);
    addr = 3'd0; wrData = 8'h82; wrEn = 1'b1; ufSet = 2'b10;
    @(negedge clk);
    wrEn = 1'b0; ufSet = '0;
    rdChk("R9", 3'd0, 8'h86);
    wr(3'd0, 8'h80);
    rdChk("R9", 3'd0, 8'h80);
    pulse(2'b01, 2'b10);
    rdChk("R8", 3'd0, 8'h89);
  endtask

  task automatic t_reserved;
    wr(3'd0, 8'hF0);
    rdChk("R10", 3'd0, 8'hB0);
    check("R10", {31'd0, suspendAll}, 32'd1);
    wr(3'd0, 8'h00);
    rdChk("R10", 3'd0, 8'h00);
    check("R10", {31'd0, suspendAll}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_window();
    t_latch();
    t_rlddis();
    t_flags();
    t_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule